// File: doc/BRIEF.md
# Isolated Driver Input Qualifier

This block is the digital front end on the primary side of an isolated gate driver. It receives a PWM command and an enable level, both already squared up by input comparators, together with a supply-good flag from the primary undervoltage monitor. The PWM line is inverted first and then debounced. The enable line is debounced the same way. The supply flag acts at once.

The block reports every change of the qualified gate state through a single-cycle strobe with a two-bit code, which the isolation transmitter sends across the barrier. When enable goes away or the supply falls out of range, it sends a forced-off command. It then keeps the gate off until both conditions are good again and a clean off level has been seen on the PWM line. The debounce length is a minimum pulse width in nanoseconds, rounded up to whole clock periods.

Top module: `gate_input_qualifier`

## Requirements
- R1: After reset no strobe is issued and the gate counts as off. An on command may only follow a qualified off level on the PWM line, even when PWM is held high through reset.
- R2: A high PWM pulse that lasts fewer than FILT_CYCLES clock samples (4 or fewer at the default 8 ns period and 40 ns minimum, where FILT_CYCLES is 5) produces no strobe.
- R3: A PWM level held for FILT_CYCLES samples is accepted. The strobe appears on the sixth rising edge after the first edge that samples the new level.
- R4: The filter runs on the inverted PWM polarity, so a short low dip while the gate is on is rejected in the same way as a short high pulse.
- R5: txValid is high for one cycle per change of the commanded state. txCode is 0 for off, 1 for on and 2 for forced shutdown, and code 3 is never sent.
- R6: When supplyOk is low at a rising edge while the gate is running, a shutdown strobe is issued on that same edge.
- R7: Enable is debounced like PWM. A low enable lasting fewer than FILT_CYCLES samples is ignored. A longer one leads to a shutdown strobe after the filter delay.
- R8: While enable or supply is missing, and after both return until the qualified PWM level is off, no on or off strobe is sent. The return to normal operation itself sends no strobe.
- R9: A shutdown strobe is sent on the loss of enable or supply even if the last command was off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwmIn | input | 1 | Digitized PWM command, high requests gate on |
| enIn | input | 1 | Digitized enable level, high allows switching |
| supplyOk | input | 1 | Primary supply above its undervoltage threshold |
| txValid | output | 1 | One-cycle strobe toward the isolation transmitter |
| txCode | output | 2 | Command code: 0 off, 1 on, 2 shutdown |

## Verification
The hardest situation to reach is the held-off state after a recovery. Here enable and supply are both good again, but PWM is still high from before the fault. The block must keep waiting without sending anything. The stimulus gets there by dropping enable or supply while PWM is high and keeping PWM high as the condition returns. It then lowers PWM and checks that the return is silent and that only the next qualified rising edge sends an on code. Pulses of exactly FILT_CYCLES and FILT_CYCLES minus one samples are also driven on both polarities and on enable.

// File: rtl/qual_pkg.sv
package qual_pkg;

  typedef enum logic [1:0] {
    TX_OFF  = 2'd0,
    TX_ON   = 2'd1,
    TX_SHUT = 2'd2
  } txCode_e;

  typedef enum logic [1:0] {
    ST_HELD = 2'd0,
    ST_ARM  = 2'd1,
    ST_RUN  = 2'd2
  } ctrlState_e;

  typedef struct packed {
    logic sendOn;
    logic sendOff;
    logic sendShut;
  } cmdStrobes_t;

  function automatic int cyclesFor(input int pulseNs, input int periodNs);
    int c;
    c = (pulseNs + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/qual_glitch_filter.sv
module qual_glitch_filter #(
  parameter int   CYCLES    = 5,
  parameter logic RST_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  logic sampled;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sampled <= RST_LEVEL;
    else       sampled <= rawIn;
  end

  generate
    if (CYCLES <= 1) begin : g_direct
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) cleanOut <= RST_LEVEL;
        else       cleanOut <= sampled;
      end
    end else begin : g_count
      localparam int CW = $clog2(CYCLES);
      logic [CW-1:0] runCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          cleanOut <= RST_LEVEL;
          runCnt   <= '0;
        end else if (sampled != cleanOut) begin
          if (runCnt == CW'(CYCLES - 1)) begin
            cleanOut <= sampled;
            runCnt   <= '0;
          end else begin
            runCnt <= runCnt + 1'b1;
          end
        end else begin
          runCnt <= '0;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/qual_datapath.sv
module qual_datapath
  import qual_pkg::*;
#(
  parameter int FILT_CYCLES = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmIn,
  input  logic        enIn,
  input  cmdStrobes_t strobes,
  output logic        pwmOn,
  output logic        enOk,
  output logic        txValid,
  output logic [1:0]  txCode
);

  logic pwmLowRaw;
  logic pwmLowClean;

  assign pwmLowRaw = ~pwmIn;

  qual_glitch_filter #(.CYCLES(FILT_CYCLES), .RST_LEVEL(1'b1)) u_pwmFilt (
    .clk(clk), .rstN(rstN), .rawIn(pwmLowRaw), .cleanOut(pwmLowClean)
  );

  qual_glitch_filter #(.CYCLES(FILT_CYCLES), .RST_LEVEL(1'b0)) u_enFilt (
    .clk(clk), .rstN(rstN), .rawIn(enIn), .cleanOut(enOk)
  );

  assign pwmOn = ~pwmLowClean;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txCode  <= TX_OFF;
    end else begin
      txValid <= strobes.sendOn | strobes.sendOff | strobes.sendShut;
      if (strobes.sendShut)     txCode <= TX_SHUT;
      else if (strobes.sendOn)  txCode <= TX_ON;
      else if (strobes.sendOff) txCode <= TX_OFF;
    end
  end

endmodule

// File: rtl/qual_control.sv
module qual_control
  import qual_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmOn,
  input  logic        enOk,
  input  logic        supplyOk,
  output cmdStrobes_t strobes
);

  ctrlState_e stateQ, stateD;
  logic       lastOnQ, lastOnD;
  logic       allowed;

  assign allowed = enOk & supplyOk;

  always_comb begin
    stateD  = stateQ;
    lastOnD = lastOnQ;
    strobes = '0;
    unique case (stateQ)
      ST_HELD: begin
        lastOnD = 1'b0;
        if (allowed) stateD = ST_ARM;
      end
      ST_ARM: begin
        lastOnD = 1'b0;
        if (!allowed)    stateD = ST_HELD;
        else if (!pwmOn) stateD = ST_RUN;
      end
      ST_RUN: begin
        if (!allowed) begin
          stateD           = ST_HELD;
          lastOnD          = 1'b0;
          strobes.sendShut = 1'b1;
        end else if (pwmOn != lastOnQ) begin
          lastOnD         = pwmOn;
          strobes.sendOn  = pwmOn;
          strobes.sendOff = ~pwmOn;
        end
      end
      default: begin
        stateD  = ST_HELD;
        lastOnD = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ  <= ST_HELD;
      lastOnQ <= 1'b0;
    end else begin
      stateQ  <= stateD;
      lastOnQ <= lastOnD;
    end
  end

endmodule

// File: rtl/gate_input_qualifier.sv
module gate_input_qualifier
  import qual_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int MIN_PULSE_NS  = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwmIn,
  input  logic       enIn,
  input  logic       supplyOk,
  output logic       txValid,
  output logic [1:0] txCode
);

  localparam int FILT_CYCLES = cyclesFor(MIN_PULSE_NS, CLK_PERIOD_NS);

  cmdStrobes_t strobes;
  logic        pwmOn;
  logic        enOk;

  qual_datapath #(.FILT_CYCLES(FILT_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .enIn(enIn), .strobes(strobes),
    .pwmOn(pwmOn), .enOk(enOk), .txValid(txValid), .txCode(txCode)
  );

  qual_control u_ctrl (
    .clk(clk), .rstN(rstN), .pwmOn(pwmOn), .enOk(enOk),
    .supplyOk(supplyOk), .strobes(strobes)
  );

endmodule

// File: rtl/qual_checker.sv
module qual_checker
  import qual_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 8,
  parameter int MIN_PULSE_NS  = 40
) (
  input logic       clk,
  input logic       rstN,
  input logic       pwmIn,
  input logic       supplyOk,
  input logic       txValid,
  input logic [1:0] txCode
);

  localparam int FC = cyclesFor(MIN_PULSE_NS, CLK_PERIOD_NS);
  localparam int RW = $clog2(FC + 1);

  logic [RW-1:0] hiRun;
  logic          longHighSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun        <= '0;
      longHighSeen <= 1'b0;
    end else begin
      if (!pwmIn)                 hiRun <= '0;
      else if (hiRun != RW'(FC))  hiRun <= hiRun + 1'b1;
      if (pwmIn && hiRun >= RW'(FC - 1))              longHighSeen <= 1'b1;
      else if (txValid && txCode == TX_ON)            longHighSeen <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (!rstN) AST_RESET_QUIET: assert (!txValid);  // R1
  end

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> txCode != 2'd3);  // R5

  AST_SHUT_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txCode == TX_SHUT) |=> !txValid);  // R5

  AST_NO_ON_WITHOUT_SUPPLY: assert property (@(posedge clk) disable iff (!rstN)
    !supplyOk |=> !(txValid && txCode == TX_ON));  // R8

  AST_ON_NEEDS_LONG_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txCode == TX_ON) |-> longHighSeen);  // R2

endmodule

bind gate_input_qualifier qual_checker #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS), .MIN_PULSE_NS(MIN_PULSE_NS)
) u_chk (
  .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .supplyOk(supplyOk),
  .txValid(txValid), .txCode(txCode)
);

// File: tb/sim_gate_input_qualifier.sv
`timescale 1ns/1ps
module sim_gate_input_qualifier;

  logic       clk = 1'b0;
  logic       rstN;
  logic       pwmIn, enIn, supplyOk;
  logic       txValid;
  logic [1:0] txCode;

  int checks = 0;
  int fails  = 0;
  int totalStrobes = 0;
  logic [1:0] lastCode = 2'd0;

  always #4 clk = ~clk;

  gate_input_qualifier u0 (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .enIn(enIn),
    .supplyOk(supplyOk), .txValid(txValid), .txCode(txCode)
  );

  always @(negedge clk) begin
    if (rstN && txValid) begin
      totalStrobes = totalStrobes + 1;
      lastCode     = txCode;
    end
  end

  typedef struct packed {
    logic       pwm;
    logic       en;
    logic       sg;
    logic [7:0] cyc;
    logic [3:0] expN;
    logic [1:0] code;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd5},  // R5 idle
    '{1'b1, 1'b1, 1'b1, 8'd12, 4'd1, 2'd1, 4'd3},  // R3 on
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd1, 2'd0, 4'd3},  // R3 off
    '{1'b1, 1'b1, 1'b1, 8'd4,  4'd0, 2'd0, 4'd2},  // R2 short high
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd2},  // R2
    '{1'b1, 1'b1, 1'b1, 8'd5,  4'd0, 2'd0, 4'd3},  // R3 exact minimum
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd2, 2'd0, 4'd3},  // R3 on then off
    '{1'b1, 1'b1, 1'b1, 8'd12, 4'd1, 2'd1, 4'd5},  // R5
    '{1'b0, 1'b1, 1'b1, 8'd4,  4'd0, 2'd0, 4'd4},  // R4 short low dip
    '{1'b1, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd4},  // R4
    '{1'b1, 1'b1, 1'b0, 8'd3,  4'd1, 2'd2, 4'd6},  // R6 supply loss
    '{1'b1, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd8},  // R8 wait, pwm still high
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd8},  // R8 silent resume
    '{1'b1, 1'b1, 1'b1, 8'd12, 4'd1, 2'd1, 4'd8},  // R8 fresh on
    '{1'b1, 1'b0, 1'b1, 8'd4,  4'd0, 2'd0, 4'd7},  // R7 enable glitch
    '{1'b1, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd7},  // R7
    '{1'b1, 1'b0, 1'b1, 8'd12, 4'd1, 2'd2, 4'd7},  // R7 enable loss
    '{1'b0, 1'b0, 1'b1, 8'd12, 4'd0, 2'd0, 4'd8},  // R8 disabled
    '{1'b1, 1'b0, 1'b1, 8'd12, 4'd0, 2'd0, 4'd8},  // R8 disabled
    '{1'b1, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd8},  // R8 enable back, pwm high
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd8},  // R8
    '{1'b0, 1'b0, 1'b1, 8'd12, 4'd1, 2'd2, 4'd9},  // R9 shutdown while off
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd9},  // R9
    '{1'b0, 1'b1, 1'b0, 8'd12, 4'd1, 2'd2, 4'd9},  // R9 supply loss while off
    '{1'b0, 1'b1, 1'b1, 8'd12, 4'd0, 2'd0, 4'd6}   // R6 recovery
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic e, input logic s, input int n,
                      output int got, output logic [1:0] lc);
    int base;
    pwmIn = p; enIn = e; supplyOk = s;
    base = totalStrobes;
    repeat (n) begin
      @(negedge clk); #1;
    end
    got = totalStrobes - base;
    lc  = lastCode;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got 0 expected 1");
    summary();
    $finish;
  end

  initial begin
    int got;
    logic [1:0] lc;
    bit quiet;
    rstN = 1'b0; pwmIn = 1'b1; enIn = 1'b1; supplyOk = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(txValid == 1'b0, "R1 strobe in reset", txValid, 0);
    rstN = 1'b1;
    @(negedge clk); #1;
    // R1: pwm high through reset must not produce an on command
    step(1'b1, 1'b1, 1'b1, 20, got, lc);
    chk(got == 0, "R1 no on after reset with pwm high", got, 0);
    step(1'b0, 1'b1, 1'b1, 12, got, lc);
    chk(got == 0, "R1 silent start", got, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].pwm, VEC[i].en, VEC[i].sg, int'(VEC[i].cyc), got, lc);
      chk(got == int'(VEC[i].expN), $sformatf("R%0d vector %0d count", VEC[i].req, i),
          got, VEC[i].expN);
      if (VEC[i].expN != 0)
        chk(lc == VEC[i].code, $sformatf("R%0d vector %0d code", VEC[i].req, i),
            lc, VEC[i].code);
    end

    // R3: exact latency, strobe on the seventh falling edge after the drive
    pwmIn = 1'b1;
    quiet = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #1;
      if (txValid) quiet = 1'b0;
    end
    chk(quiet, "R3 early strobe", !quiet, 0);
    @(negedge clk); #1;
    chk(txValid && txCode == 2'd1, "R3 strobe timing", {txValid, txCode}, 3'b101);
    @(negedge clk); #1;
    chk(!txValid, "R5 single cycle", txValid, 0);
    step(1'b1, 1'b1, 1'b1, 8, got, lc);

    // R6: supply loss acts on the next edge
    supplyOk = 1'b0;
    @(negedge clk); #1;
    chk(txValid && txCode == 2'd2, "R6 immediate shutdown", {txValid, txCode}, 3'b110);
    step(1'b1, 1'b1, 1'b0, 6, got, lc);
    chk(got == 0, "R6 no repeat while held", got, 0);
    step(1'b0, 1'b1, 1'b1, 12, got, lc);
    chk(got == 0, "R8 silent recovery", got, 0);

    summary();
    $finish;
  end

endmodule